// File: doc/BRIEF.md
# Core Timer with Periodic Interrupt and Watchdog

The core timer is a free-running binary divider chain clocked by the bus clock. From one chain it derives three events. An overflow event fires each time the low stage of the chain wraps. A periodic tick fires at one of four selectable rates. A watchdog timeout fires when software fails to service the block within a window. The watchdog timeout is counted in periodic ticks, so the timeout scales with the selected rate.

Software reaches the block through one 8-bit control/status register. This register holds two interrupt enables, two write-one-to-clear bits, the two event flags and a 2-bit rate code. The block combines the enabled flags into one interrupt request. A watchdog-service strobe restarts the watchdog stage and the upper part of the chain. It leaves the low part of the chain running, so the next timeout falls between seven and eight periodic intervals after the service.

The watchdog is a small state machine with three states:
- `WD_COUNT` counts periodic ticks. It moves to `WD_LAST` on the tick that brings the count to its top value.
- `WD_LAST` waits for one more tick. A service strobe sends it back to `WD_COUNT`. A tick without a service strobe sends it to `WD_BITE` and restarts the chain.
- `WD_BITE` drives the one-cycle reset pulse. It always returns to `WD_COUNT` on the next cycle.
- A service strobe in any state clears the watchdog count.

Top module: `ctmr_core`

## Requirements
- R1: After reset, `ctl_rdata` reads 8'hC0. This means the rate code in bits 7:6 is 2'b11, the enables in bits 3:2 are 0 and the flags in bits 1:0 are 0. After reset, `irq_o` and `wdog_rst_o` are also 0.
- R2: The overflow flag (bit 0) is set on each cycle where the low OVF_W bits of the chain wrap to zero. This happens first 2^OVF_W cycles after the chain starts and then every 2^OVF_W cycles.
- R3: With rate code n in bits 7:6, the periodic flag (bit 1) is set once every 2^(TAP_BASE+n) cycles. The first set comes half a period after the chain starts.
- R4: Writing 1 to bit 4 clears the overflow flag, and writing 1 to bit 5 clears the periodic flag. Writing 0 to either bit leaves its flag unchanged. Bits 5:4 always read 0.
- R5: If a flag-set event and a clearing write land in the same cycle, the flag stays set.
- R6: `irq_o` is high exactly when either of these holds: the overflow flag and its enable (bit 2) are both set, or the periodic flag and its enable (bit 3) are both set.
- R7: Without service, `wdog_rst_o` pulses high for exactly one cycle on the eighth periodic tick after the chain starts. This is 7.5 periodic intervals after the start.
- R8: The watchdog pulse restarts the chain from zero. The overflow and periodic events then resume their timing relative to the pulse cycle.
- R9: A service strobe clears the watchdog count and the chain bits above the selected tap, and leaves the lower bits running. The next pulse comes on the eighth tick after the strobe. A tick in the same cycle as the strobe is not counted.
- R10: A write loads the enables (bits 3:2) and the rate code (bits 7:6), and these fields read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Register write strobe |
| ctl_wdata | input | 8 | Register write data |
| ctl_rdata | output | 8 | Register read data |
| wdog_kick_i | input | 1 | Watchdog service strobe |
| irq_o | output | 1 | Combined interrupt request |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Two pairs of actions can fall in the same cycle. The first pair is a watchdog service and a periodic tick. The second pair is a flag-set event and a write-one-to-clear to the same flag.

The bench sweeps the service strobe across every cycle of a window that spans several tick edges. It also places a service exactly on the tick that would otherwise trigger the timeout. In each case it computes the first tick strictly after the strobe, then the eighth tick after that, and requires the pulse on that cycle and on no earlier one.

For the flags, the bench times a clearing write onto the exact cycle where the overflow or periodic event fires, and expects the flag to remain set.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int RATE_W   = 2;
    localparam int NUM_TAPS = 1 << RATE_W;
    localparam int REG_W    = 8;

    // control/status register bit positions
    localparam int RB_OVF_FLG = 0;
    localparam int RB_PER_FLG = 1;
    localparam int RB_OVF_EN  = 2;
    localparam int RB_PER_EN  = 3;
    localparam int RB_OVF_CLR = 4;
    localparam int RB_PER_CLR = 5;
    localparam int RB_RATE_LO = 6;

    typedef logic [RATE_W-1:0] rate_t;

    typedef enum logic [1:0] {
        WD_COUNT = 2'd0,
        WD_LAST  = 2'd1,
        WD_BITE  = 2'd2
    } wd_state_e;

endpackage

// File: rtl/ctmr_chain.sv
module ctmr_chain
    import ctmr_pkg::*;
#(
    parameter int TAP_BASE = 11,
    parameter int OVF_W    = 8,
    parameter int CW       = TAP_BASE + NUM_TAPS - 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  rate_t         rate_i,
    input  logic          svc_i,
    input  logic          restart_i,
    output logic          ovf_evt_o,
    output logic          tick_evt_o,
    output logic [CW-1:0] count_o
);

    logic [CW-1:0]       cnt_q;
    logic [CW-1:0]       cnt_d;
    logic [NUM_TAPS-1:0] tick_c;
    logic [CW-1:0]       keep_mask [NUM_TAPS];

    // One candidate tick per rate code; tap bit index TB rises every 2^(TB+1) cycles
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int TB = TAP_BASE - 1 + i;
        assign tick_c[i]    = (&cnt_q[TB-1:0]) & ~cnt_q[TB];
        assign keep_mask[i] = CW'((64'd1 << (TB + 1)) - 64'd1);
    end

    assign tick_evt_o = tick_c[rate_i];
    assign ovf_evt_o  = &cnt_q[OVF_W-1:0];
    assign count_o    = cnt_q;

    always_comb begin
        if (restart_i) begin
            cnt_d = '0;
        end else if (svc_i) begin
            cnt_d = (cnt_q + 1'b1) & keep_mask[rate_i];
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R9: service leaves the bits below the fastest tap counting on
    p_svc_keeps_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (svc_i && !restart_i) |=>
            cnt_q[TAP_BASE-2:0] == (TAP_BASE-1)'($past(cnt_q[TAP_BASE-2:0]) + 1'b1));

endmodule

// File: rtl/ctmr_regs.sv
module ctmr_regs
    import ctmr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             ovf_evt_i,
    input  logic             tick_evt_i,
    output logic [REG_W-1:0] rdata_o,
    output rate_t            rate_o,
    output logic             irq_o
);

    logic  ovf_en_q, per_en_q;
    logic  ovf_flg_q, per_flg_q;
    rate_t rate_q;
    logic  ovf_clr, per_clr;
    logic  unused_ro_bits;

    assign unused_ro_bits = ^wdata_i[RB_PER_FLG:RB_OVF_FLG];
    assign ovf_clr = we_i & wdata_i[RB_OVF_CLR];
    assign per_clr = we_i & wdata_i[RB_PER_CLR];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ovf_en_q  <= 1'b0;
            per_en_q  <= 1'b0;
            rate_q    <= '1;
            ovf_flg_q <= 1'b0;
            per_flg_q <= 1'b0;
        end else begin
            if (we_i) begin
                ovf_en_q <= wdata_i[RB_OVF_EN];
                per_en_q <= wdata_i[RB_PER_EN];
                rate_q   <= wdata_i[RB_RATE_LO +: RATE_W];
            end
            // set has priority over a clearing write
            ovf_flg_q <= ovf_evt_i  | (ovf_flg_q & ~ovf_clr);
            per_flg_q <= tick_evt_i | (per_flg_q & ~per_clr);
        end
    end

    always_comb begin
        rdata_o                          = '0;
        rdata_o[RB_OVF_FLG]              = ovf_flg_q;
        rdata_o[RB_PER_FLG]              = per_flg_q;
        rdata_o[RB_OVF_EN]               = ovf_en_q;
        rdata_o[RB_PER_EN]               = per_en_q;
        rdata_o[RB_RATE_LO +: RATE_W]    = rate_q;
    end

    assign rate_o = rate_q;
    assign irq_o  = (ovf_flg_q & ovf_en_q) | (per_flg_q & per_en_q);

    // R5: a set event always leaves the flag high
    p_ovf_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_evt_i |=> ovf_flg_q);
    p_per_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_evt_i |=> per_flg_q);
    // R4: clear with no competing set drops the flag
    p_per_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (per_clr && !tick_evt_i) |=> !per_flg_q);
    // R4: a write with the clear bit low keeps a set flag
    p_ovf_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && !wdata_i[RB_OVF_CLR] && ovf_flg_q) |=> ovf_flg_q);

endmodule

// File: rtl/ctmr_wdog.sv
module ctmr_wdog
    import ctmr_pkg::*;
#(
    parameter int WD_W = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic kick_i,
    output logic bite_o,
    output logic wdog_rst_o
);

    localparam logic [WD_W-1:0] CNT_MAX = '1;

    wd_state_e       state_q, state_d;
    logic [WD_W-1:0] cnt_q, cnt_d;

    // next-state and event logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bite_o  = 1'b0;
        unique case (state_q)
            WD_COUNT: begin
                if (kick_i) begin
                    cnt_d = '0;
                end else if (tick_i) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNT_MAX - 1'b1) begin
                        state_d = WD_LAST;
                    end
                end
            end
            WD_LAST: begin
                if (kick_i) begin
                    cnt_d   = '0;
                    state_d = WD_COUNT;
                end else if (tick_i) begin
                    cnt_d   = '0;
                    state_d = WD_BITE;
                    bite_o  = 1'b1;
                end
            end
            WD_BITE: begin
                state_d = WD_COUNT;
                if (kick_i) begin
                    cnt_d = '0;
                end
            end
            default: begin
                state_d = WD_COUNT;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= WD_COUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        wdog_rst_o = (state_q == WD_BITE);
    end

    // R7: reset pulse lasts a single cycle
    p_bite_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdog_rst_o |=> !wdog_rst_o);
    // R7: each unserviced tick advances the count by one
    p_tick_advance_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !kick_i && state_q == WD_COUNT) |=> cnt_q == $past(cnt_q) + 1'b1);
    // R9: service restarts the count and blocks a pulse
    p_kick_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_i |=> (cnt_q == '0) && !wdog_rst_o);

endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
    import ctmr_pkg::*;
#(
    parameter int TAP_BASE = 11,
    parameter int OVF_W    = 8,
    parameter int WD_W     = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       wdog_kick_i,
    output logic       irq_o,
    output logic       wdog_rst_o
);

    localparam int CW = TAP_BASE + NUM_TAPS - 1;

    rate_t         rate;
    logic          ovf_evt, tick_evt, bite;
    logic [CW-1:0] chain_cnt;

    ctmr_chain #(
        .TAP_BASE (TAP_BASE),
        .OVF_W    (OVF_W),
        .CW       (CW)
    ) chain_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rate_i     (rate),
        .svc_i      (wdog_kick_i),
        .restart_i  (bite),
        .ovf_evt_o  (ovf_evt),
        .tick_evt_o (tick_evt),
        .count_o    (chain_cnt)
    );

    ctmr_regs regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (ctl_we),
        .wdata_i    (ctl_wdata),
        .ovf_evt_i  (ovf_evt),
        .tick_evt_i (tick_evt),
        .rdata_o    (ctl_rdata),
        .rate_o     (rate),
        .irq_o      (irq_o)
    );

    ctmr_wdog #(
        .WD_W (WD_W)
    ) wdog_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_evt),
        .kick_i     (wdog_kick_i),
        .bite_o     (bite),
        .wdog_rst_o (wdog_rst_o)
    );

    // R8: the pulse cycle sees the chain restarted from zero
    p_bite_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdog_rst_o |-> chain_cnt == '0);

endmodule

// File: tb/ctmr_core_tb.sv
`timescale 1ns/1ps
module ctmr_core_tb_top;

    localparam int TB_BASE = 6;
    localparam int TB_OVF  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       kick = 1'b0;
    logic       irq, wrst;

    int errors = 0;
    int checks = 0;
    int edges = 0;
    int last_bite = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ctmr_core #(.TAP_BASE(TB_BASE), .OVF_W(TB_OVF), .WD_W(3)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ctl_we(we), .ctl_wdata(wdata),
        .ctl_rdata(rdata), .wdog_kick_i(kick), .irq_o(irq), .wdog_rst_o(wrst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, edges, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        edges++;
        if (wrst) last_bite = edges;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; we = 1'b0; kick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        edges = 0;
        last_bite = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        we = 1'b1; wdata = d;
        step();
        we = 1'b0;
    endtask

    task automatic kick_now();
        kick = 1'b1;
        step();
        kick = 1'b0;
    endtask

    task automatic run_to(input int t);
        while (edges < t) step();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 rdata", rdata, 8'hC0);
        chk("R1 irq", irq, 0);
        chk("R1 wdog_rst", wrst, 0);

        // R2 / R4 / R5 / R6 / R10 on the overflow flag
        run_to(15);          chk("R2 ovf before wrap", rdata[0], 0);
        step();              chk("R2 ovf at wrap", rdata[0], 1);
        wr(8'hC0);           chk("R4 zero write keeps flag", rdata[0], 1);
        chk("R4 clear bits read 0", rdata[5:4], 0);
        wr(8'hD0);           chk("R4 ovf cleared", rdata[0], 0);
        run_to(31);          chk("R2 ovf before 2nd wrap", rdata[0], 0);
        step();              chk("R2 ovf at 2nd wrap", rdata[0], 1);
        chk("R6 irq masked", irq, 0);
        wr(8'hC4);           chk("R6 irq enabled", irq, 1);
        chk("R10 readback", rdata, 8'hC5);
        wr(8'hD4);           chk("R6 irq after clear", irq, 0);
        run_to(47);
        wr(8'hD4);           chk("R5 ovf set wins", rdata[0], 1);
        chk("R5 irq stays", irq, 1);

        // R3 / R5 / R6 / R10 periodic rate sweep
        for (int n = 0; n < 4; n++) begin
            int p;
            p = 1 << (TB_BASE + n);
            do_reset();
            wr(8'(n << 6));
            chk("R10 rate readback", rdata[7:6], n);
            run_to(p/2 - 1); chk("R3 per before first tick", rdata[1], 0);
            step();          chk("R3 per first tick", rdata[1], 1);
            wr(8'(n << 6) | 8'h28);
            chk("R4 per cleared", rdata[1], 0);
            chk("R6 irq off", irq, 0);
            run_to(p/2 + p - 1); chk("R3 per before second tick", rdata[1], 0);
            step();          chk("R3 per second tick", rdata[1], 1);
            chk("R6 irq per", irq, 1);
            run_to(5*p/2 - 1);
            wr(8'(n << 6) | 8'h28);
            chk("R5 per set wins", rdata[1], 1);
        end

        // R7 / R8 unserviced watchdog per rate
        for (int n = 0; n < 4; n++) begin
            int p, e;
            p = 1 << (TB_BASE + n);
            e = p/2 + 7*p;
            do_reset();
            wr(8'(n << 6));
            run_to(e - 1);   chk("R7 no early pulse", last_bite, 0);
            step();          chk("R7 pulse", wrst, 1);
            step();          chk("R7 pulse one cycle", wrst, 0);
            wr(8'(n << 6) | 8'h30);
            run_to(e + 15);  chk("R8 ovf before restart wrap", rdata[0], 0);
            step();          chk("R8 ovf after restart", rdata[0], 1);
            run_to(e + p/2 - 1); chk("R8 per before restart tick", rdata[1], 0);
            step();          chk("R8 per after restart", rdata[1], 1);
            run_to(2*e - 1); chk("R7 no extra pulse", last_bite, e);
            step();          chk("R7 second pulse", wrst, 1);
        end

        // R9 service sweep at the fastest rate
        for (int k = 20; k <= 100; k++) begin
            int p, t1, bx;
            p = 1 << TB_BASE;
            if (k < p/2) t1 = p/2;
            else         t1 = p/2 + ((k - p/2)/p + 1)*p;
            bx = t1 + 7*p;
            do_reset();
            wr(8'h00);
            run_to(k - 1);
            kick_now();
            run_to(bx - 1);  chk("R9 no pulse before eighth tick", last_bite, 0);
            step();          chk("R9 pulse after service", wrst, 1);
        end

        // R9 service on the very tick that would time out
        begin
            int p, e;
            p = 1 << (TB_BASE + 2);
            e = p/2 + 7*p;
            do_reset();
            wr(8'h80);
            run_to(e - 1);
            kick_now();      chk("R9 coincident service blocks pulse", wrst, 0);
            run_to(e + 8*p - 1); chk("R9 no pulse in window", last_bite, 0);
            step();          chk("R9 pulse after coincident service", wrst, 1);
        end

        // R9 / R10 service then rate change
        do_reset();
        run_to(299);
        kick_now();
        wr(8'h40);
        run_to(1215);        chk("R10 no pulse after rate change", last_bite, 0);
        step();              chk("R9 pulse at new rate", wrst, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule